// File: doc/BRIEF.md
# Current-Limit Fault Response Controller

This controller decides what a power output does after an external comparator reports that the load current has reached its limit. It watches an enable request, a current-limit flag and a thermal-shutdown flag. It drives a gate-enable output and an active-low fault line. A two-bit strap picks one of three overcurrent policies. The first, hold, keeps the output on and leaves regulation to the analog loop. The second, latch-off, turns the output off after a long overcurrent and keeps it off until the enable request is cycled. The third, hiccup retry, switches the output on and off in fixed periods for as long as the overload lasts.

Every duration is a count of clock cycles set by a parameter: the deglitch filter, the base and extra latch-off delays, the retry on and off times, and the enable-low time that clears a reported fault. All inputs are plain levels sampled on the rising clock edge. Both outputs come from registers. A condition sampled at one edge is visible on the outputs right after that edge.

Top module: `ilim_guard`

## Requirements
- R1: The strap is captured only while `rst_n` is low and holds from then on. 2'b00 selects hold, 2'b01 and 2'b11 select latch-off, and 2'b10 selects retry. During reset `gate_en` is 0 and `fault_n` is 1.
- R2: At an edge where `en_in` is sampled high and no thermal or latched condition applies, `gate_en` goes to 1. At an edge where `en_in` is sampled low, `gate_en` goes to 0.
- R3: With the output on, `fault_n` falls at the edge where `ilim_hit` has been sampled high on DEGLITCH_CYC consecutive edges. A shorter run of high samples leaves `fault_n` at 1.
- R4: In hold mode the output stays on for any length of current-limit run.
- R5: In latch-off mode `gate_en` falls at the edge that completes DEGLITCH_CYC+BASE_DLY_CYC+EXTRA_DLY_CYC consecutive high samples of `ilim_hit`.
- R6: A latched-off output stays off while `en_in` stays high, even after `ilim_hit` clears. It turns on again only after `en_in` has been sampled low and then high.
- R7: In retry mode `gate_en` falls when a run reaches DEGLITCH_CYC+RETRY_ON_CYC high samples. It comes back on after RETRY_OFF_CYC further edges with `en_in` high. A new deglitch and on window then starts.
- R8: In retry mode, a reported fault clears after RETRY_ON_CYC consecutive edges with the output on and `ilim_hit` low.
- R9: In any mode, a reported fault clears at the edge that completes FAULT_HOLD_CYC+1 consecutive low samples of `en_in`. A shorter low period leaves it reported.
- R10: With `en_in` high, a sampled `tsd_flag` turns the output off and pulls `fault_n` low. When the flag drops, the output turns back on. A latched-off output stays latched.
- R11: A low sample of `en_in` restarts every delay count, so a limit run broken by an enable-low period is timed from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| en_in | input | 1 | Debounced enable request for the output |
| ilim_hit | input | 1 | Current-limit comparator flag |
| tsd_flag | input | 1 | Thermal-shutdown flag |
| mode_strap | input | 2 | Overcurrent policy select (see R1) |
| gate_en | output | 1 | Output switch enable, high = on |
| fault_n | output | 1 | Fault report, low = fault |

## Verification
The bench targets the off-by-one edges of each window: a limit run one sample short of the deglitch, latch or retry threshold, an enable-low period one sample short of the fault-hold time, and the last edge of the retry off phase. A design that counts one too many or too few would move `gate_en` or `fault_n` one cycle early or late. A design that lets thermal recovery or a stray strap change release a latched output would turn the gate back on while `en_in` stays high. A design that keeps counters across an enable-low period would trip too early after re-enable.

// File: rtl/ilim_guard_pkg.sv
package ilim_guard_pkg;

  typedef enum logic [1:0] {
    POL_HOLD  = 2'd0,
    POL_LATCH = 2'd1,
    POL_RETRY = 2'd2
  } policy_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_LATCH = 3'd2,
    ST_COOL  = 3'd3,
    ST_THERM = 3'd4
  } state_e;

  // Strap decode: the unused code falls back to the safe latch-off policy.
  function automatic policy_e decode_strap(input logic [1:0] strap);
    case (strap)
      2'b00:   return POL_HOLD;
      2'b10:   return POL_RETRY;
      default: return POL_LATCH;
    endcase
  endfunction

endpackage

// File: rtl/ilim_sat_cnt.sv
// Run-length counter: counts consecutive cycles with inc high, saturates at
// LIMIT, and drops to zero on the first cycle inc is low.
module ilim_sat_cnt #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt_nxt
);

  logic [W-1:0] cnt_q;

  always_comb begin
    if (!inc)                      cnt_nxt = '0;
    else if (cnt_q == W'(LIMIT))   cnt_nxt = cnt_q;
    else                           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/ilim_guard_fsm.sv
module ilim_guard_fsm
  import ilim_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_in,
  input  logic    tsd_flag,
  input  logic    ilim_hit,
  input  policy_e policy,
  input  logic    run_qual,   // limit run has passed the deglitch window
  input  logic    lat_trip,   // limit run reached the latch-off threshold
  input  logic    ret_trip,   // limit run reached the retry on-window end
  input  logic    cool_done,  // retry off-window complete
  input  logic    low_done,   // enable low long enough to clear the fault
  input  logic    calm_done,  // retry: limit absent for a full on-window
  output state_e  state_q,
  output logic    flt_q
);

  state_e state_d;
  logic   flt_d;

  always_comb begin
    state_d = state_q;
    if (!en_in) begin
      state_d = ST_IDLE;
    end else if (tsd_flag && state_q != ST_LATCH) begin
      state_d = ST_THERM;
    end else begin
      case (state_q)
        ST_IDLE, ST_THERM: state_d = ST_ON;
        ST_ON: begin
          if (policy == POL_LATCH && lat_trip)      state_d = ST_LATCH;
          else if (policy == POL_RETRY && ret_trip) state_d = ST_COOL;
        end
        ST_COOL:  if (cool_done) state_d = ST_ON;
        ST_LATCH: state_d = ST_LATCH;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    flt_d = flt_q;
    if (low_done)       flt_d = 1'b0;
    else if (calm_done) flt_d = 1'b0;
    else if (run_qual)  flt_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      flt_q   <= flt_d;
    end
  end

  AST_HOLD_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_HOLD && state_q == ST_ON && en_in && !tsd_flag) |=> (state_q == ST_ON)); // R4

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LATCH && en_in) |=> (state_q == ST_LATCH)); // R6

  AST_FLT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> $past(ilim_hit && en_in)); // R3

endmodule

// File: rtl/ilim_guard.sv
module ilim_guard
  import ilim_guard_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC   = 3,
  parameter int unsigned BASE_DLY_CYC   = 4,
  parameter int unsigned EXTRA_DLY_CYC  = 5,
  parameter int unsigned RETRY_ON_CYC   = 6,
  parameter int unsigned RETRY_OFF_CYC  = 7,
  parameter int unsigned FAULT_HOLD_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  input  logic       ilim_hit,
  input  logic       tsd_flag,
  input  logic [1:0] mode_strap,
  output logic       gate_en,
  output logic       fault_n
);

  localparam int unsigned LAT_TRIP = DEGLITCH_CYC + BASE_DLY_CYC + EXTRA_DLY_CYC;
  localparam int unsigned RET_TRIP = DEGLITCH_CYC + RETRY_ON_CYC;
  localparam int unsigned RUN_MAX  = (LAT_TRIP > RET_TRIP) ? LAT_TRIP : RET_TRIP;
  localparam int unsigned LOW_MAX  = FAULT_HOLD_CYC + 1;
  localparam int unsigned RUN_W    = $clog2(RUN_MAX + 1);
  localparam int unsigned LOW_W    = $clog2(LOW_MAX + 1);
  localparam int unsigned CALM_W   = $clog2(RETRY_ON_CYC + 1);
  localparam int unsigned COOL_W   = $clog2(RETRY_OFF_CYC + 1);

  policy_e policy_q;
  state_e  state_q;
  logic    flt_q;

  // Strap is captured only during reset.
  always_ff @(posedge clk) begin
    if (!rst_n) policy_q <= decode_strap(mode_strap);
  end

  logic on_ok, run_inc, calm_inc, cool_inc, low_inc;
  assign on_ok    = (state_q == ST_ON) && en_in && !tsd_flag;
  assign run_inc  = on_ok && ilim_hit;
  assign calm_inc = on_ok && !ilim_hit && (policy_q == POL_RETRY);
  assign cool_inc = (state_q == ST_COOL) && en_in && !tsd_flag;
  assign low_inc  = !en_in;

  logic [RUN_W-1:0]  run_nxt;
  logic [LOW_W-1:0]  low_nxt;
  logic [CALM_W-1:0] calm_nxt;
  logic [COOL_W-1:0] cool_nxt;

  ilim_sat_cnt #(.LIMIT(RUN_MAX),       .W(RUN_W))  u_run  (.clk(clk), .rst_n(rst_n), .inc(run_inc),  .cnt_nxt(run_nxt));
  ilim_sat_cnt #(.LIMIT(LOW_MAX),       .W(LOW_W))  u_low  (.clk(clk), .rst_n(rst_n), .inc(low_inc),  .cnt_nxt(low_nxt));
  ilim_sat_cnt #(.LIMIT(RETRY_ON_CYC),  .W(CALM_W)) u_calm (.clk(clk), .rst_n(rst_n), .inc(calm_inc), .cnt_nxt(calm_nxt));
  ilim_sat_cnt #(.LIMIT(RETRY_OFF_CYC), .W(COOL_W)) u_cool (.clk(clk), .rst_n(rst_n), .inc(cool_inc), .cnt_nxt(cool_nxt));

  logic run_qual, lat_trip, ret_trip, cool_done, low_done, calm_done;
  assign run_qual  = run_inc && (run_nxt >= RUN_W'(DEGLITCH_CYC));
  assign lat_trip  = (run_nxt == RUN_W'(LAT_TRIP));
  assign ret_trip  = (run_nxt == RUN_W'(RET_TRIP));
  assign cool_done = (cool_nxt == COOL_W'(RETRY_OFF_CYC));
  assign low_done  = (low_nxt == LOW_W'(LOW_MAX));
  assign calm_done = (calm_nxt == CALM_W'(RETRY_ON_CYC));

  ilim_guard_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_in     (en_in),
    .tsd_flag  (tsd_flag),
    .ilim_hit  (ilim_hit),
    .policy    (policy_q),
    .run_qual  (run_qual),
    .lat_trip  (lat_trip),
    .ret_trip  (ret_trip),
    .cool_done (cool_done),
    .low_done  (low_done),
    .calm_done (calm_done),
    .state_q   (state_q),
    .flt_q     (flt_q)
  );

  assign gate_en = (state_q == ST_ON);
  assign fault_n = !(flt_q || state_q == ST_THERM);

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(policy_q)); // R1

  AST_GATE_OFF_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_in |=> !gate_en); // R2

  AST_THERM_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && tsd_flag) |=> !gate_en); // R10

  AST_THERM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && tsd_flag && state_q != ST_LATCH) |=> !fault_n); // R10

  AST_FAULT_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> ($past(!en_in) || $past(!ilim_hit) || $past(state_q == ST_THERM))); // R9

endmodule

// File: tb/test_ilim_guard.sv
`timescale 1ns/1ps
module test_ilim_guard;

  localparam int DG   = 3;
  localparam int BD   = 4;
  localparam int XD   = 5;
  localparam int RON  = 6;
  localparam int ROFF = 7;
  localparam int FH   = 5;
  localparam int LAT  = DG + BD + XD;
  localparam int RET  = DG + RON;
  localparam int RMAX = (LAT > RET) ? LAT : RET;

  // model state codes
  localparam int M_IDLE = 0, M_ON = 1, M_LATCH = 2, M_COOL = 3, M_THERM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_in = 1'b0, ilim_hit = 1'b0, tsd_flag = 1'b0;
  logic [1:0] mode_strap = 2'b00;
  logic gate_en, fault_n;

  always #2.5 clk = ~clk;

  ilim_guard #(
    .DEGLITCH_CYC(DG), .BASE_DLY_CYC(BD), .EXTRA_DLY_CYC(XD),
    .RETRY_ON_CYC(RON), .RETRY_OFF_CYC(ROFF), .FAULT_HOLD_CYC(FH)
  ) i_ilim_guard (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .ilim_hit(ilim_hit),
    .tsd_flag(tsd_flag), .mode_strap(mode_strap),
    .gate_en(gate_en), .fault_n(fault_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference: policy 0 hold, 1 latch, 2 retry.
  int m_pol, m_st, m_run, m_low, m_calm, m_cool;
  bit m_flt, m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pol  = (mode_strap == 2'b00) ? 0 : (mode_strap == 2'b10) ? 2 : 1;
      m_st   = M_IDLE;
      m_run  = 0; m_low = 0; m_calm = 0; m_cool = 0;
      m_flt  = 0;
    end else begin
      bit on_ok;
      on_ok  = (m_st == M_ON) && en_in && !tsd_flag;
      m_run  = (on_ok && ilim_hit) ? ((m_run < RMAX) ? m_run + 1 : RMAX) : 0;
      m_calm = (on_ok && !ilim_hit && m_pol == 2) ? ((m_calm < RON) ? m_calm + 1 : RON) : 0;
      m_cool = (m_st == M_COOL && en_in && !tsd_flag) ? ((m_cool < ROFF) ? m_cool + 1 : ROFF) : 0;
      m_low  = !en_in ? ((m_low < FH + 1) ? m_low + 1 : FH + 1) : 0;
      if (m_low == FH + 1)                   m_flt = 0;
      else if (m_calm == RON)                m_flt = 0;
      else if (on_ok && ilim_hit && m_run >= DG) m_flt = 1;
      if (!en_in) m_st = M_IDLE;
      else if (tsd_flag && m_st != M_LATCH) m_st = M_THERM;
      else if (m_st == M_IDLE || m_st == M_THERM) m_st = M_ON;
      else if (m_st == M_ON) begin
        if (m_pol == 1 && m_run == LAT) m_st = M_LATCH;
        else if (m_pol == 2 && m_run == RET) m_st = M_COOL;
      end else if (m_st == M_COOL && m_cool == ROFF) m_st = M_ON;
    end
    m_valid = 1;
  end

  // Model comparison on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !done) begin
      logic eg, ef;
      eg = (m_st == M_ON);
      ef = !(m_flt || m_st == M_THERM);
      checks++;
      if (gate_en !== eg || fault_n !== ef) begin
        errors++;
        $display("FAIL %s model: gate_en=%0b fault_n=%0b expected gate_en=%0b fault_n=%0b at %0t",
                 cur_req, gate_en, fault_n, eg, ef, $time);
      end
    end
  end

  task automatic step(input logic e, input logic l, input logic t);
    en_in = e; ilim_hit = l; tsd_flag = t;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic eg, input logic ef);
    checks++;
    if (gate_en !== eg || fault_n !== ef) begin
      errors++;
      $display("FAIL %s: gate_en=%0b fault_n=%0b expected gate_en=%0b fault_n=%0b",
               req, gate_en, fault_n, eg, ef);
    end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    rst_n = 1'b0; mode_strap = strap;
    en_in = 1'b0; ilim_hit = 1'b0; tsd_flag = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b1);
    rst_n = 1'b1;
    mode_strap = ~strap;  // strap changes after reset must be ignored
  endtask

  initial begin
    @(negedge clk);
    // ---------------- hold policy ----------------
    do_reset(2'b00);
    cur_req = "R2";
    step(1, 0, 0);                         chk("R2", 1, 1);
    cur_req = "R3";
    repeat (DG - 1) step(1, 1, 0);
    step(1, 0, 0);                         chk("R3", 1, 1);
    repeat (DG) step(1, 1, 0);             chk("R3", 1, 0);
    cur_req = "R4";
    repeat (30) step(1, 1, 0);             chk("R4", 1, 0);
    cur_req = "R10";
    step(1, 1, 1);                         chk("R10", 0, 0);
    step(1, 1, 0);                         chk("R10", 1, 0);
    cur_req = "R9";
    repeat (FH) step(0, 0, 0);             chk("R9", 0, 0);
    step(0, 0, 0);                         chk("R9", 0, 1);
    step(0, 0, 0);                         chk("R2", 0, 1);

    // ---------------- latch-off policy ----------------
    do_reset(2'b01);
    step(1, 0, 0);
    cur_req = "R5";
    repeat (LAT - 1) step(1, 1, 0);        chk("R5", 1, 0);
    step(1, 1, 0);                         chk("R5", 0, 0);
    cur_req = "R6";
    repeat (3) step(1, 0, 0);              chk("R6", 0, 0);
    step(1, 0, 1);                         chk("R10", 0, 0);
    step(1, 0, 0);                         chk("R6", 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);                         chk("R6", 1, 0);  // short low keeps fault (R9)
    cur_req = "R11";
    repeat (LAT - 1) step(1, 1, 0);
    step(0, 1, 0);
    step(1, 1, 0);
    repeat (LAT - 1) step(1, 1, 0);        chk("R11", 1, 0);
    step(1, 1, 0);                         chk("R11", 0, 0);

    // ---------------- retry policy ----------------
    do_reset(2'b10);
    step(1, 0, 0);
    cur_req = "R7";
    repeat (RET - 1) step(1, 1, 0);        chk("R7", 1, 0);
    step(1, 1, 0);                         chk("R7", 0, 0);
    repeat (ROFF - 1) step(1, 0, 0);       chk("R7", 0, 0);
    step(1, 0, 0);                         chk("R7", 1, 0);
    cur_req = "R8";
    repeat (RON - 1) step(1, 0, 0);        chk("R8", 1, 0);
    step(1, 0, 0);                         chk("R8", 1, 1);
    cur_req = "R7";
    repeat (RET) step(1, 1, 0);            chk("R7", 0, 0);
    repeat (ROFF) step(1, 1, 0);           chk("R7", 1, 0);

    // ---------------- spare strap code ----------------
    do_reset(2'b11);
    cur_req = "R1";
    step(1, 0, 0);
    repeat (LAT) step(1, 1, 0);            chk("R1", 0, 0);
    step(1, 0, 0);                         chk("R1", 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule